// File: doc/BRIEF.md
# Delay-Line Gray Code Counter

This block counts up by one on every clock cycle in which its count enable is high, and presents the count both as plain binary and as a reflected binary Gray code. The Gray value is not formed from the binary value by XOR for every bit. Each of the low-order Gray bits is a complemented, time-shifted copy of one binary bit. A chain of registers that advances only on enabled steps supplies that delay. The delay doubles from one Gray bit to the next. The upper Gray bits would need long chains, and they change rarely, so they are derived from the binary register with ordinary XORs.

For a delayed Gray bit j, the source is binary bit j+1 and the chain is 2^j stages long. Because binary bit j+1 of (b - 2^j) is the complement of Gray bit j of b, the chain output is inverted once at the output. On reset, the chain registers are preloaded with the values the binary counter would have had on the steps leading up to zero. As a result, the Gray output is valid on the first cycle after reset.

Top module: `gray_dl_counter`

## Requirements
- R1: In the cycle after synchronous reset `rst` is high at a clock edge, `bin_o` and `gray_o` are both all zeros.
- R2: On each rising edge with `en_i` high and `rst` low, `bin_o` increases by one modulo 2^N. The value wraps from all ones to zero.
- R3: `gray_o` always equals `bin_o ^ (bin_o >> 1)` (reflected binary Gray code), including directly after reset.
- R4: For each bit position j below DL_BITS, `gray_o[j]` equals the complement of bit j+1 of the binary count reached 2^j enabled steps earlier. Steps before a reset count as if the counter had counted up to zero.
- R5: For each bit position j from DL_BITS to N-2, `gray_o[j]` equals `bin_o[j] ^ bin_o[j+1]`, and `gray_o[N-1]` equals `bin_o[N-1]`.
- R6: A clock edge with `en_i` low and `rst` low leaves both `bin_o` and `gray_o` unchanged.
- R7: Each enabled step changes exactly one bit of `gray_o`, including the step that wraps all ones back to zero.
- R8: A reset applied in the middle of counting returns the block to the R1 state, and the counting that follows again satisfies R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Count enable; advances counter and delay chains |
| gray_o | output | N | Reflected binary Gray code of the count |
| bin_o | output | N | Binary count |

## Verification
The bench counts past the wrap from all ones to zero. A delay chain preloaded with the wrong history, or one that shifts at the wrong time, would then show a Gray value that disagrees with the binary count, or two bits flipping in one step. Enable is toggled in short irregular patterns. Chains that shift while the counter holds, or the reverse, would slip out of phase, and the per-bit delay check would catch that. A reset is applied mid-count to confirm that the preload restores a Gray output that is valid at once, rather than a state that needs 2^j steps to flush.

// File: rtl/gray_dl_pkg.sv
package gray_dl_pkg;

    localparam int unsigned GDL_WIDTH_DEF   = 8;
    localparam int unsigned GDL_DELAYED_DEF = 5;

    // Number of chain stages that carry Gray bit j.
    function automatic int unsigned chain_depth(input int unsigned j);
        return 32'd1 << j;
    endfunction

    // Bit 'bitpos' of the n-bit value (0 - back) mod 2^n: the binary count
    // 'back' enabled steps before zero.
    function automatic logic history_bit(input int unsigned n,
                                         input int unsigned bitpos,
                                         input int unsigned back);
        longint unsigned v;
        v = ((64'd1 << n) - 64'(back)) & ((64'd1 << n) - 64'd1);
        return v[bitpos];
    endfunction

endpackage

// File: rtl/gdl_bin_counter.sv
module gdl_bin_counter #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    output logic [N-1:0] cnt_o
);
    logic [N-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (en_i) cnt_q <= cnt_q + {{(N-1){1'b0}}, 1'b1};
    end

    assign cnt_o = cnt_q;

    // R2
    step_incr_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && !$past(rst)) |=> (cnt_q == $past(cnt_q) + {{(N-1){1'b0}}, 1'b1}));

endmodule

// File: rtl/gdl_delay_chain.sv
module gdl_delay_chain
    import gray_dl_pkg::*;
#(
    parameter int unsigned N      = 8,
    parameter int unsigned SRCBIT = 1,
    parameter int unsigned DEPTH  = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic din_i,
    output logic dout_o
);
    logic [DEPTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < int'(DEPTH); s++)
                stage_q[s] <= history_bit(N, SRCBIT, s + 1);
        end else if (en_i) begin
            stage_q[0] <= din_i;
            for (int s = 1; s < int'(DEPTH); s++)
                stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout_o = stage_q[DEPTH-1];

    // R6
    chain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !$past(rst)) |=> $stable(stage_q));

endmodule

// File: rtl/gdl_upper_xor.sv
module gdl_upper_xor #(
    parameter int unsigned W = 3
) (
    input  logic [W-1:0] bin_i,
    output logic [W-1:0] gray_o
);
    for (genvar k = 0; k < W; k++) begin : g_bit
        if (k == W - 1) begin : g_top
            assign gray_o[k] = bin_i[k];
        end else begin : g_mid
            assign gray_o[k] = bin_i[k] ^ bin_i[k+1];
        end
    end
endmodule

// File: rtl/gray_dl_counter.sv
module gray_dl_counter
    import gray_dl_pkg::*;
#(
    parameter int unsigned N       = GDL_WIDTH_DEF,
    parameter int unsigned DL_BITS = GDL_DELAYED_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    output logic [N-1:0] gray_o,
    output logic [N-1:0] bin_o
);
    localparam int unsigned UPPER_W = N - DL_BITS;

    if (DL_BITS < 1 || DL_BITS > N - 1) begin : g_bad_cfg
        $error("DL_BITS must lie in 1..N-1");
    end

    logic [N-1:0] bin_w;
    logic [N-1:0] gray_w;

    gdl_bin_counter #(.N(N)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .en_i  (en_i),
        .cnt_o (bin_w)
    );

    for (genvar j = 0; j < DL_BITS; j++) begin : g_chain
        logic tap_w;
        gdl_delay_chain #(
            .N      (N),
            .SRCBIT (j + 1),
            .DEPTH  (chain_depth(j))
        ) u_dl (
            .clk    (clk),
            .rst    (rst),
            .en_i   (en_i),
            .din_i  (bin_w[j+1]),
            .dout_o (tap_w)
        );
        assign gray_w[j] = ~tap_w;
    end

    gdl_upper_xor #(.W(UPPER_W)) u_up (
        .bin_i  (bin_w[N-1:DL_BITS]),
        .gray_o (gray_w[N-1:DL_BITS])
    );

    assign gray_o = gray_w;
    assign bin_o  = bin_w;

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (gray_o == '0 && bin_o == '0));

    // R3
    gray_match_chk: assert property (@(posedge clk) disable iff (rst)
        gray_o == (bin_o ^ (bin_o >> 1)));

    // R7
    one_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && !$past(rst)) |=> ($countones(gray_o ^ $past(gray_o)) == 1));

    // R6
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !$past(rst)) |=> ($stable(gray_o) && $stable(bin_o)));

endmodule

// File: tb/gray_dl_counter_tb_top.sv
module gray_dl_counter_tb_top;
    localparam int N  = 8;
    localparam int DL = 5;

    typedef struct {
        bit rst;
        bit en;
        int steps;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic [N-1:0] gray_w;
    logic [N-1:0] bin_w;

    item_t q[$];
    int    ref_steps = 0;
    int    checks    = 0;
    int    failures  = 0;
    bit    have_prev = 1'b0;
    logic [N-1:0] prev_gray;
    logic [N-1:0] prev_bin;

    always #5 clk = ~clk;

    gray_dl_counter #(.N(N), .DL_BITS(DL)) dut_i (
        .clk    (clk),
        .rst    (rst),
        .en_i   (en),
        .gray_o (gray_w),
        .bin_o  (bin_w)
    );

    function automatic logic [N-1:0] mod_val(input int v);
        int m;
        m = v % (1 << N);
        if (m < 0) m += (1 << N);
        return m[N-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected item.
    task automatic drive(input bit r, input bit e);
        item_t it;
        @(negedge clk);
        rst = r;
        en  = e;
        if (r) ref_steps = 0;
        else if (e) ref_steps++;
        it.rst = r; it.en = e; it.steps = ref_steps;
        q.push_back(it);
    endtask

    // Monitor: pops one expected item per clock edge and compares.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            item_t it;
            logic [N-1:0] eb;
            logic [N-1:0] eg;
            it = q.pop_front();
            eb = mod_val(it.steps);
            eg = eb ^ (eb >> 1);
            if (it.rst) begin
                // R1 / R8: zero state after reset
                check(bin_w == '0, "R1", "bin after reset", bin_w, 0);
                check(gray_w == '0, "R1", "gray after reset", gray_w, 0);
            end else begin
                // R2: binary count
                check(bin_w == eb, "R2", "binary count", bin_w, eb);
                // R3: Gray relation
                check(gray_w == eg, "R3", "gray value", gray_w, eg);
                // R4: delayed low bits
                for (int j = 0; j < DL; j++) begin
                    logic [N-1:0] past_b;
                    logic exp_bit;
                    past_b  = mod_val(it.steps - (1 << j));
                    exp_bit = ~past_b[j+1];
                    check(gray_w[j] == exp_bit, "R4", $sformatf("delayed bit %0d", j),
                          gray_w[j], exp_bit);
                end
                // R5: XOR-derived upper bits
                for (int j = DL; j < N; j++) begin
                    logic exp_bit;
                    exp_bit = (j == N - 1) ? bin_w[j] : (bin_w[j] ^ bin_w[j+1]);
                    check(gray_w[j] == exp_bit, "R5", $sformatf("upper bit %0d", j),
                          gray_w[j], exp_bit);
                end
                if (have_prev) begin
                    if (it.en) begin
                        // R7: single bit change
                        check($countones(gray_w ^ prev_gray) == 1, "R7", "bits changed",
                              $countones(gray_w ^ prev_gray), 1);
                    end else begin
                        // R6: frozen outputs
                        check(gray_w == prev_gray, "R6", "gray held", gray_w, prev_gray);
                        check(bin_w == prev_bin, "R6", "bin held", bin_w, prev_bin);
                    end
                end
            end
            prev_gray = gray_w;
            prev_bin  = bin_w;
            have_prev = 1'b1;
        end
    end

    initial begin
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);
        // full run through the wrap (R2, R7)
        for (int i = 0; i < 300; i++) drive(1'b0, 1'b1);
        // irregular enable pattern (R4, R6)
        for (int i = 0; i < 40; i++) drive(1'b0, (i % 3) != 0);
        for (int i = 0; i < 5; i++) drive(1'b0, 1'b0);
        // mid-count reset (R8)
        drive(1'b1, 1'b1);
        for (int i = 0; i < 60; i++) drive(1'b0, (i % 5) != 2);
        drive(1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule